// File: doc/BRIEF.md
# Uni-directional Weighted Prediction Pixel Pipeline

This block turns intermediate-precision inter-prediction samples into 8-bit pixels. It applies an explicit weight, a level shift, a rounding term, a right shift and an additive offset to each sample. It then clamps the result to the pixel range. The block works on one rectangular block at a time. A single start pulse captures the weight, offset, level shift, shift amount, width and height. The block folds the level shift, offset and rounding into one 32-bit constant at that moment. Each sample then costs one multiply, one add and one arithmetic shift.

Samples arrive on a valid/ready stream as beats of four signed 16-bit lanes. Each beat holds four horizontally adjacent samples of one row, and rows come in raster order. Every accepted beat yields one beat of four pixels on the output stream. Beats leave in the order they arrived, three register stages later. A row marker flags the final beat of each row. A one-cycle completion pulse follows the block's final output beat.

Top module: `wpred_uni`

## Requirements
- R1: Each output lane equals clamp(((src + lvl) * wgt + 2^(sh-1)) >>> sh + off, 0, 255), where src, wgt, lvl and off are signed 16-bit values. Input lane i is `in_data[16i+15:16i]` and output lane i is `out_data[8i+7:8i]`.
- R2: For every shift amount from 1 to 14 the shift is arithmetic. Results below zero give pixel 0 and results above 255 give pixel 255, because saturation runs through an unsigned 16-bit stage and then an 8-bit stage.
- R3: With `out_ready` held high and input always offered, a beat accepted in cycle c appears on the output in cycle c+3. The block accepts one beat in every cycle until the whole block has been taken.
- R4: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and `out_data` unchanged. No beat is lost or repeated.
- R5: `out_last` is high exactly on the output beat that ends a row, which is every (width/4)-th beat. It is never high without `out_valid`.
- R6: `done` is high for exactly one cycle, directly after the transfer of the block's final output beat. `busy` is low in that same cycle.
- R7: A start with width or height below one beat row (width < 4 or height 0) leaves `busy`, `in_ready`, `out_valid` and `done` low.
- R8: Configuration inputs are captured only by a start while idle. A start pulse or configuration change during a block has no effect on that block's outputs.
- R9: `in_ready` is low while idle, and from the moment the block's final input beat has been accepted.
- R10: After reset, `busy`, `done`, `in_ready`, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; captures configuration when idle |
| cfg_wgt | input | 16 | Signed weight |
| cfg_off | input | 16 | Signed offset added after the shift |
| cfg_lvl | input | 16 | Signed level shift added to each sample |
| cfg_shift | input | SH_W | Right-shift amount, 1 to 14 |
| cfg_width | input | DIM_W | Block width in samples, a multiple of 4 |
| cfg_height | input | DIM_W | Block height in rows |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse after the final output beat |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | LANES*16 | Four signed samples, lane 0 in the low bits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | LANES*8 | Four pixels, lane 0 in the low bits |
| out_last | output | 1 | Output beat ends a row |

## Verification
Two pairs of events can fall in the same cycle. The first is input acceptance together with output emission. The second is an output stall together with a pending input. Both are provoked by driving `in_valid` and `out_ready` from independent random percentages, across a sweep of all shift amounts and several weight, offset and level-shift sets. Every output beat is judged in order against arithmetic computed in the bench, and every stalled cycle is judged for a held output. A second coincidence pairs a start pulse with an active block. It is provoked by pulsing start with scrambled configuration mid-block, and judged by the unchanged pixels that follow.

// File: rtl/wpred_pkg.sv
package wpred_pkg;

    localparam int SAMP_W  = 16;
    localparam int PIX_W   = 8;
    localparam int ACC_W   = 32;
    localparam int MID_W   = 16;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic [MID_W-1:0]         mid_t;

    typedef struct packed {
        logic row_end;
        logic blk_end;
    } beat_tag_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FEED,
        SQ_DRAIN
    } seq_state_t;

    // Block constant: level shift times weight, offset scaled up, rounding half.
    function automatic acc_t fold_const(samp_t wgt, samp_t off, samp_t lvl,
                                        logic [4:0] sh);
        acc_t prod;
        acc_t offs;
        acc_t half;
        prod = acc_t'(lvl) * acc_t'(wgt);
        offs = acc_t'(off) <<< sh;
        half = (sh == 5'd0) ? acc_t'(0) : (acc_t'(1) <<< (sh - 5'd1));
        return prod + offs + half;
    endfunction

    // Signed 32 -> unsigned 16 -> unsigned 8 saturation.
    function automatic pix_t clamp_pix(acc_t v);
        mid_t m;
        if (v < acc_t'(0))
            m = '0;
        else if (v > acc_t'({1'b0, {MID_W{1'b1}}}))
            m = '1;
        else
            m = v[MID_W-1:0];
        if (m > mid_t'({PIX_W{1'b1}}))
            return '1;
        return m[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/wpred_param.sv
module wpred_param
    import wpred_pkg::*;
#(
    parameter int SH_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  samp_t           wgt_in,
    input  samp_t           off_in,
    input  samp_t           lvl_in,
    input  logic [SH_W-1:0] sh_in,
    output samp_t           wgt_q,
    output logic [SH_W-1:0] sh_q,
    output acc_t            k_q
);

    logic [4:0] sh5;
    assign sh5 = 5'(sh_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            wgt_q <= '0;
            sh_q  <= '0;
            k_q   <= '0;
        end else if (load) begin
            wgt_q <= wgt_in;
            sh_q  <= sh_in;
            k_q   <= fold_const(wgt_in, off_in, lvl_in, sh5);
        end
    end

endmodule

// File: rtl/wpred_seq.sv
module wpred_seq
    import wpred_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic             adv,
    input  logic             in_valid,
    input  logic             out_fire,
    input  logic             out_blk_end,
    output logic             busy,
    output logic             in_ready,
    output logic             take,
    output beat_tag_t        tag,
    output logic             done
);

    localparam int LG = $clog2(LANES);
    localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

    seq_state_t       st;
    logic [DIM_W-1:0] bpr_q;
    logic [DIM_W-1:0] rows_q;
    logic [DIM_W-1:0] col_q;
    logic [DIM_W-1:0] row_q;
    logic [DIM_W-1:0] bpr_in;
    logic             empty;

    assign bpr_in   = width >> LG;
    assign empty    = (bpr_in == '0) || (height == '0);
    assign busy     = (st != SQ_IDLE);
    assign in_ready = (st == SQ_FEED) && adv;
    assign take     = in_valid && in_ready;

    assign tag.row_end = (col_q == bpr_q - ONE);
    assign tag.blk_end = tag.row_end && (row_q == rows_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            bpr_q  <= '0;
            rows_q <= '0;
            col_q  <= '0;
            row_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (start && !empty) begin
                        bpr_q  <= bpr_in;
                        rows_q <= height;
                        col_q  <= '0;
                        row_q  <= '0;
                        st     <= SQ_FEED;
                    end
                end
                SQ_FEED: begin
                    if (take) begin
                        if (tag.blk_end) begin
                            st <= SQ_DRAIN;
                        end else if (tag.row_end) begin
                            col_q <= '0;
                            row_q <= row_q + ONE;
                        end else begin
                            col_q <= col_q + ONE;
                        end
                    end
                end
                SQ_DRAIN: begin
                    if (out_fire && out_blk_end) begin
                        st   <= SQ_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wpred_lane.sv
module wpred_lane
    import wpred_pkg::*;
#(
    parameter int SH_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  samp_t           src,
    input  samp_t           wgt,
    input  acc_t            k,
    input  logic [SH_W-1:0] sh,
    output pix_t            pix
);

    acc_t prod_q;
    acc_t sum_q;
    acc_t shifted;

    assign shifted = sum_q >>> sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            sum_q  <= '0;
            pix    <= '0;
        end else if (adv) begin
            prod_q <= acc_t'(src) * acc_t'(wgt);
            sum_q  <= prod_q + k;
            pix    <= clamp_pix(shifted);
        end
    end

endmodule

// File: rtl/wpred_uni.sv
module wpred_uni
    import wpred_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DIM_W = 12,
    parameter int SH_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [SAMP_W-1:0]        cfg_wgt,
    input  logic [SAMP_W-1:0]        cfg_off,
    input  logic [SAMP_W-1:0]        cfg_lvl,
    input  logic [SH_W-1:0]          cfg_shift,
    input  logic [DIM_W-1:0]         cfg_width,
    input  logic [DIM_W-1:0]         cfg_height,
    output logic                     busy,
    output logic                     done,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANES*SAMP_W-1:0]  in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANES*PIX_W-1:0]   out_data,
    output logic                     out_last
);

    localparam int STAGES = 3;

    logic            adv;
    logic            take;
    logic            load;
    beat_tag_t       tag_in;
    samp_t           wgt_q;
    logic [SH_W-1:0] sh_q;
    acc_t            k_q;

    logic      [STAGES-1:0] vld_q;
    beat_tag_t              tag_q [STAGES];

    assign adv  = !vld_q[STAGES-1] || out_ready;
    assign load = start && !busy;

    wpred_param #(.SH_W(SH_W)) u_param (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .wgt_in (samp_t'(cfg_wgt)),
        .off_in (samp_t'(cfg_off)),
        .lvl_in (samp_t'(cfg_lvl)),
        .sh_in  (cfg_shift),
        .wgt_q  (wgt_q),
        .sh_q   (sh_q),
        .k_q    (k_q)
    );

    wpred_seq #(.LANES(LANES), .DIM_W(DIM_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .width       (cfg_width),
        .height      (cfg_height),
        .adv         (adv),
        .in_valid    (in_valid),
        .out_fire    (out_valid && out_ready),
        .out_blk_end (tag_q[STAGES-1].blk_end),
        .busy        (busy),
        .in_ready    (in_ready),
        .take        (take),
        .tag         (tag_in),
        .done        (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int s = 0; s < STAGES; s++) tag_q[s] <= '0;
        end else if (adv) begin
            vld_q    <= {vld_q[STAGES-2:0], take};
            tag_q[0] <= tag_in;
            for (int s = 1; s < STAGES; s++) tag_q[s] <= tag_q[s-1];
        end
    end

    assign out_valid = vld_q[STAGES-1];
    assign out_last  = vld_q[STAGES-1] && tag_q[STAGES-1].row_end;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wpred_lane #(.SH_W(SH_W)) u_lane (
            .clk (clk),
            .rst (rst),
            .adv (adv),
            .src (samp_t'(in_data[g*SAMP_W +: SAMP_W])),
            .wgt (wgt_q),
            .k   (k_q),
            .sh  (sh_q),
            .pix (out_data[g*PIX_W +: PIX_W])
        );
    end

endmodule

// File: rtl/wpred_chk.sv
module wpred_chk #(
    parameter int LANES = 4,
    parameter int DIM_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [DIM_W-1:0]   cfg_width,
    input logic [DIM_W-1:0]   cfg_height,
    input logic               busy,
    input logic               done,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [LANES*8-1:0] out_data,
    input logic               out_last
);

    // R9
    idle_noready_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !in_ready);

    // R4
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(out_valid && out_ready && out_last)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    empty_block_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (cfg_width < DIM_W'(LANES) || cfg_height == '0)) |=> !busy);

endmodule

bind wpred_uni wpred_chk #(.LANES(LANES), .DIM_W(DIM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cfg_width  (cfg_width),
    .cfg_height (cfg_height),
    .busy       (busy),
    .done       (done),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last)
);

// File: tb/sim_wpred_uni.sv
module sim_wpred_uni;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int DIM_W      = 12;
    localparam int SH_W       = 5;
    localparam int WATCHDOG   = 150000;
    localparam int MAXB       = 256;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   start = 1'b0;
    logic [15:0]            cfg_wgt = '0, cfg_off = '0, cfg_lvl = '0;
    logic [SH_W-1:0]        cfg_shift = '0;
    logic [DIM_W-1:0]       cfg_width = '0, cfg_height = '0;
    logic                   busy, done, in_ready, out_valid, out_last;
    logic                   in_valid = 1'b0, out_ready = 1'b0;
    logic [LANES*16-1:0]    in_data = '0;
    logic [LANES*8-1:0]     out_data;

    int n_chk = 0;
    int n_bad = 0;
    int sat_lo = 0;
    int sat_hi = 0;
    logic [LANES*16-1:0] src_mem [MAXB];

    wpred_uni #(.LANES(LANES), .DIM_W(DIM_W), .SH_W(SH_W)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_pix(int src, int wgt, int off, int lvl, int sh);
        longint t;
        t = ((longint'(src) + lvl) * wgt + (longint'(1) <<< (sh - 1))) >>> sh;
        t = t + off;
        if (t < 0) return 0;
        if (t > 255) return 255;
        return int'(t);
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "R6", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic run_block(input int w, input int h, input int wgt, input int off,
                             input int lvl, input int sh, input int vpct,
                             input int rpct, input bit mid_start, input bit lat_chk);
        int nb, bpr, ni, no, cyc, first_in, first_out, last_out;
        bit stall, bad_data, bad_last, bad_hold, bad_rdy, bad_done;
        logic [LANES*8-1:0] held;
        nb = (w / 4) * h;
        bpr = w / 4;
        for (int b = 0; b < nb; b++)
            for (int l = 0; l < LANES; l++)
                src_mem[b][16*l +: 16] = 16'($urandom);
        src_mem[0] = {16'h7fff, 16'h8000, 16'h0000, 16'hffff};
        @(negedge clk);
        cfg_wgt = 16'(wgt); cfg_off = 16'(off); cfg_lvl = 16'(lvl);
        cfg_shift = SH_W'(sh); cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble configuration after capture
        cfg_wgt = 16'h1234; cfg_off = 16'h0777; cfg_lvl = 16'h4000; cfg_shift = SH_W'(3);
        cfg_width = DIM_W'(4); cfg_height = DIM_W'(1);
        ni = 0; no = 0; cyc = 0; first_in = -1; first_out = -1; last_out = -1;
        stall = 0; bad_data = 0; bad_last = 0; bad_hold = 0; bad_rdy = 0; bad_done = 0;
        held = '0;
        while (no < nb) begin
            in_valid  = (ni < nb) && ($urandom_range(99) < vpct);
            in_data   = src_mem[ni < nb ? ni : 0];
            out_ready = ($urandom_range(99) < rpct);
            start     = mid_start && (cyc == 2);
            #1;
            if (stall && (!out_valid || out_data !== held)) begin
                bad_hold = 1;
                check(1'b0, "R4", "held beat changed", longint'(out_data), longint'(held));
            end
            if (ni == nb && in_ready) bad_rdy = 1;
            if (done) bad_done = 1;
            if (in_valid && in_ready) begin
                if (first_in < 0) first_in = cyc;
                ni++;
            end
            if (out_valid && first_out < 0) first_out = cyc;
            stall = out_valid && !out_ready;
            held  = out_data;
            if (out_valid && out_ready) begin
                for (int l = 0; l < LANES; l++) begin
                    int e, a;
                    e = ref_pix(int'($signed(src_mem[no][16*l +: 16])), wgt, off, lvl, sh);
                    a = int'(out_data[8*l +: 8]);
                    if (e == 0) sat_lo++;
                    if (e == 255) sat_hi++;
                    if (a != e) begin
                        bad_data = 1;
                        check(1'b0, "R1", $sformatf("beat %0d lane %0d sh %0d", no, l, sh), a, e);
                    end
                end
                if (out_last !== ((no % bpr) == bpr - 1)) begin
                    bad_last = 1;
                    check(1'b0, "R5", $sformatf("row marker beat %0d", no), out_last, (no % bpr) == bpr - 1);
                end
                last_out = cyc;
                no++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; in_valid = 1'b0;
        #1;
        check(!bad_data, "R1", "block pixel values", bad_data, 0);
        check(!bad_last, "R5", "row markers", bad_last, 0);
        check(!bad_hold, "R4", "stall hold", bad_hold, 0);
        check(!bad_rdy, "R9", "in_ready after final input", bad_rdy, 0);
        check(!bad_done, "R6", "no early done", bad_done, 0);
        check(done === 1'b1, "R6", "done after final beat", done, 1);
        check(busy === 1'b0, "R6", "busy low with done", busy, 0);
        if (lat_chk) begin
            check(first_out == first_in + 3, "R3", "latency", first_out, first_in + 3);
            check(last_out == first_out + nb - 1, "R3", "throughput", last_out, first_out + nb - 1);
        end
        @(negedge clk);
        #1;
        check(done === 1'b0, "R6", "done one cycle", done, 0);
    endtask

    task automatic empty_block(input int w, input int h);
        bit bad;
        bad = 0;
        @(negedge clk);
        cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        start = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            if (busy || in_ready || out_valid || done) bad = 1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(!bad, "R7", $sformatf("empty block %0dx%0d stays idle", w, h), bad, 0);
    endtask

    initial begin
        int wl [4] = '{64, -7, 255, 1};
        int ol [4] = '{0, -20, 100, 7};
        int ll [4] = '{0, -8192, 1000, 5};
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !in_ready && !out_valid && !out_last, "R10", "reset outputs",
              {busy, done, in_ready, out_valid, out_last}, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!busy && !in_ready && !out_valid, "R10", "idle after reset",
              {busy, in_ready, out_valid}, 0);
        check(!in_ready, "R9", "in_ready low when idle", in_ready, 0);
        for (int sh = 1; sh <= 14; sh++)
            for (int k = 0; k < 4; k++)
                run_block(8, 4, wl[k], ol[k], ll[k], sh, 70, 60, 1'b0, 1'b0);
        run_block(16, 8, 64, 3, -300, 6, 100, 100, 1'b0, 1'b1);
        run_block(8, 8, -90, 40, 2000, 4, 80, 25, 1'b1, 1'b0);
        run_block(32, 16, 200, -50, -4000, 9, 90, 50, 1'b0, 1'b0);
        empty_block(0, 8);
        empty_block(8, 0);
        empty_block(2, 4);
        check(sat_lo > 0, "R2", "lanes saturating to 0 seen", sat_lo, 1);
        check(sat_hi > 0, "R2", "lanes saturating to 255 seen", sat_hi, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule